// File: doc/BRIEF.md
# Bus Channel Stall and Throughput Probe

This block sits beside one AXI4 manager port and watches it without driving anything. It samples the valid, ready and sizing signals of the write-address, write-data, write-response, read-address and read-data channels, together with a single busy flag from the engine that owns the port. From these it derives sixteen event amounts every clock cycle. The events cover stalls in both directions, handshake completions, and byte counts.

Stalls are reported in both directions. A "stall" means the manager offers data and the subordinate holds it back. A "starve" or "hold" means one side is ready and the other has nothing, or the other side cannot take what is offered. This separates downstream backpressure from upstream starvation. Byte counts are taken for a whole burst at address handshakes and for a single beat at data handshakes.

Every event amount is registered and appears one cycle after the bus cycle that caused it. Beside each amount the block keeps a wide running total. The total wraps on overflow and does not saturate. A counter bank or a testbench can read the totals directly.

Top module: `axi_traffic_probe`

## Requirements
- R1: Slot 0 (write-address stall) is 1 when aw_valid=1 and aw_ready=0, else 0. Slot 1 (read-address stall) follows the same rule using ar_valid and ar_ready.
- R2: Slot 2 (write-data stall) is 1 when w_valid=1 and w_ready=0. Slot 3 (read-data starve) is 1 when r_ready=1 and r_valid=0. Both are 0 otherwise.
- R3: Slot 4 (write-data starve) is 1 when w_ready=1 and w_valid=0. Slot 5 (read-data hold) is 1 when r_valid=1 and r_ready=0. Both are 0 otherwise.
- R4: Slots 6, 7, 8, 9 and 10 are the handshake counts of the write-address, read-address, write-data, read-data and write-response channels. Each is 1 in a cycle where that channel's valid and ready are both 1, else 0.
- R5: On a write-address handshake, slot 11 equals (aw_len+1) << aw_size. On a read-address handshake, slot 12 equals (ar_len+1) << ar_size. Each slot is 0 in a cycle without its handshake.
- R6: On a write-data handshake, slot 13 equals the number of set bits in w_strb. On a read-data handshake, slot 14 equals DATA_W/8. Each slot is 0 in a cycle without its handshake.
- R7: Slot 15 (busy) is 1 in every cycle in which busy is 1, else 0.
- R8: Each amount appears on evt_inc_o one cycle after the input cycle that produced it. Slot k occupies bits [k*16 +: 16].
- R9: The total in slot k (bits [k*48 +: 48] of evt_total_o) is updated on the same edge as the amount. It equals the sum, modulo 2^48, of every slot-k amount since reset.
- R10: An active-low reset, asynchronous, clears every amount and every total to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aw_valid | input | 1 | Write-address valid |
| aw_ready | input | 1 | Write-address ready |
| aw_len | input | 8 | Write burst length minus one |
| aw_size | input | 3 | Write beat size, log2 bytes |
| w_valid | input | 1 | Write-data valid |
| w_ready | input | 1 | Write-data ready |
| w_strb | input | DATA_W/8 | Write byte strobes |
| b_valid | input | 1 | Write-response valid |
| b_ready | input | 1 | Write-response ready |
| ar_valid | input | 1 | Read-address valid |
| ar_ready | input | 1 | Read-address ready |
| ar_len | input | 8 | Read burst length minus one |
| ar_size | input | 3 | Read beat size, log2 bytes |
| r_valid | input | 1 | Read-data valid |
| r_ready | input | 1 | Read-data ready |
| busy | input | 1 | Engine busy flag |
| evt_inc_o | output | 16*16 | Registered per-cycle event amounts, slot k at [k*16 +: 16] |
| evt_total_o | output | 16*48 | Running totals, slot k at [k*48 +: 48] |

## Verification
The bench applies several kinds of traffic:
- Each channel is driven valid-without-ready, then ready-without-valid. This tells a stall apart from a starve on the same channel.
- Full handshakes are driven on all five channels at once. This confirms that stall slots stay silent while done and byte slots fire.
- Burst sizes range from one byte to the largest length and size encoding, and strobe patterns vary. This separates burst-byte arithmetic from beat-byte counting.
- An all-idle cycle follows each pattern and a reset is applied mid-run. These expose amounts that are held too long and totals that do not return to zero.

// File: rtl/probe_pkg.sv
package probe_pkg;
    localparam int NUM_EV = 16;
    localparam int LEN_W  = 8;
    localparam int SIZE_W = 3;
    // Widest amount: (2^LEN_W) << (2^SIZE_W - 1) needs LEN_W+1 + 2^SIZE_W-1 bits.
    localparam int INC_W  = LEN_W + 1 + (2 ** SIZE_W) - 1;

    localparam int EV_AW_STALL = 0;
    localparam int EV_AR_STALL = 1;
    localparam int EV_W_STALL  = 2;
    localparam int EV_R_STARVE = 3;
    localparam int EV_W_STARVE = 4;
    localparam int EV_R_HOLD   = 5;
    localparam int EV_AW_DONE  = 6;
    localparam int EV_AR_DONE  = 7;
    localparam int EV_W_DONE   = 8;
    localparam int EV_R_DONE   = 9;
    localparam int EV_B_DONE   = 10;
    localparam int EV_AW_BYTES = 11;
    localparam int EV_AR_BYTES = 12;
    localparam int EV_W_BYTES  = 13;
    localparam int EV_R_BYTES  = 14;
    localparam int EV_BUSY     = 15;

    typedef logic [INC_W-1:0] inc_t;
endpackage

// File: rtl/probe_burst_bytes.sv
module probe_burst_bytes #(
    parameter int LEN_W  = 8,
    parameter int SIZE_W = 3,
    parameter int OUT_W  = 16
) (
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size,
    output logic [OUT_W-1:0]  bytes
);
    localparam int BEATS_W = LEN_W + 1;

    logic [BEATS_W-1:0] beats;

    always_comb begin
        beats = {1'b0, len} + BEATS_W'(1);
        bytes = OUT_W'(beats) << size;
    end
endmodule

// File: rtl/probe_popcount.sv
module probe_popcount #(
    parameter int N     = 8,
    parameter int OUT_W = 16
) (
    input  logic [N-1:0]     bits,
    output logic [OUT_W-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + OUT_W'(bits[i]);
        end
    end
endmodule

// File: rtl/probe_event_decode.sv
module probe_event_decode
    import probe_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              aw_valid,
    input  logic              aw_ready,
    input  logic [LEN_W-1:0]  aw_len,
    input  logic [SIZE_W-1:0] aw_size,
    input  logic              w_valid,
    input  logic              w_ready,
    input  logic [STRB_W-1:0] w_strb,
    input  logic              b_valid,
    input  logic              b_ready,
    input  logic              ar_valid,
    input  logic              ar_ready,
    input  logic [LEN_W-1:0]  ar_len,
    input  logic [SIZE_W-1:0] ar_size,
    input  logic              r_valid,
    input  logic              r_ready,
    input  logic              busy,
    output inc_t              ev_amt [NUM_EV]
);
    localparam inc_t BEAT_BYTES = INC_W'(STRB_W);

    inc_t aw_burst_bytes;
    inc_t ar_burst_bytes;
    inc_t w_beat_bytes;

    probe_burst_bytes #(.LEN_W(LEN_W), .SIZE_W(SIZE_W), .OUT_W(INC_W)) u_aw_bytes (
        .len   (aw_len),
        .size  (aw_size),
        .bytes (aw_burst_bytes)
    );

    probe_burst_bytes #(.LEN_W(LEN_W), .SIZE_W(SIZE_W), .OUT_W(INC_W)) u_ar_bytes (
        .len   (ar_len),
        .size  (ar_size),
        .bytes (ar_burst_bytes)
    );

    probe_popcount #(.N(STRB_W), .OUT_W(INC_W)) u_w_strb_cnt (
        .bits  (w_strb),
        .count (w_beat_bytes)
    );

    logic aw_hs, ar_hs, w_hs, r_hs, b_hs;

    always_comb begin
        aw_hs = aw_valid & aw_ready;
        ar_hs = ar_valid & ar_ready;
        w_hs  = w_valid  & w_ready;
        r_hs  = r_valid  & r_ready;
        b_hs  = b_valid  & b_ready;

        ev_amt[EV_AW_STALL] = INC_W'(aw_valid & ~aw_ready);
        ev_amt[EV_AR_STALL] = INC_W'(ar_valid & ~ar_ready);
        ev_amt[EV_W_STALL]  = INC_W'(w_valid  & ~w_ready);
        ev_amt[EV_R_STARVE] = INC_W'(r_ready  & ~r_valid);
        ev_amt[EV_W_STARVE] = INC_W'(w_ready  & ~w_valid);
        ev_amt[EV_R_HOLD]   = INC_W'(r_valid  & ~r_ready);

        ev_amt[EV_AW_DONE]  = INC_W'(aw_hs);
        ev_amt[EV_AR_DONE]  = INC_W'(ar_hs);
        ev_amt[EV_W_DONE]   = INC_W'(w_hs);
        ev_amt[EV_R_DONE]   = INC_W'(r_hs);
        ev_amt[EV_B_DONE]   = INC_W'(b_hs);

        ev_amt[EV_AW_BYTES] = aw_hs ? aw_burst_bytes : '0;
        ev_amt[EV_AR_BYTES] = ar_hs ? ar_burst_bytes : '0;
        ev_amt[EV_W_BYTES]  = w_hs  ? w_beat_bytes   : '0;
        ev_amt[EV_R_BYTES]  = r_hs  ? BEAT_BYTES     : '0;

        ev_amt[EV_BUSY]     = INC_W'(busy);
    end
endmodule

// File: rtl/probe_accum.sv
module probe_accum
    import probe_pkg::*;
#(
    parameter int TOT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  inc_t             ev_amt [NUM_EV],
    output inc_t             inc_q  [NUM_EV],
    output logic [TOT_W-1:0] tot_q  [NUM_EV]
);
    typedef struct {
        inc_t             inc [NUM_EV];
        logic [TOT_W-1:0] tot [NUM_EV];
    } acc_state_t;

    acc_state_t st_d;

    always_comb begin
        for (int k = 0; k < NUM_EV; k++) begin
            st_d.inc[k] = ev_amt[k];
            st_d.tot[k] = tot_q[k] + TOT_W'(ev_amt[k]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_EV; k++) begin
                inc_q[k] <= '0;
                tot_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < NUM_EV; k++) begin
                inc_q[k] <= st_d.inc[k];
                tot_q[k] <= st_d.tot[k];
            end
        end
    end

    // R9: every total moves by exactly the amount shown beside it
    for (genvar g = 0; g < NUM_EV; g++) begin : g_chk
        a_r9_total_step: assert property (@(posedge clk) disable iff (!rst_n)
            tot_q[g] == $past(tot_q[g]) + TOT_W'(inc_q[g]));
    end
endmodule

// File: rtl/axi_traffic_probe.sv
module axi_traffic_probe
    import probe_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int TOT_W  = 48,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      aw_valid,
    input  logic                      aw_ready,
    input  logic [LEN_W-1:0]          aw_len,
    input  logic [SIZE_W-1:0]         aw_size,
    input  logic                      w_valid,
    input  logic                      w_ready,
    input  logic [STRB_W-1:0]         w_strb,
    input  logic                      b_valid,
    input  logic                      b_ready,
    input  logic                      ar_valid,
    input  logic                      ar_ready,
    input  logic [LEN_W-1:0]          ar_len,
    input  logic [SIZE_W-1:0]         ar_size,
    input  logic                      r_valid,
    input  logic                      r_ready,
    input  logic                      busy,
    output logic [NUM_EV*INC_W-1:0]   evt_inc_o,
    output logic [NUM_EV*TOT_W-1:0]   evt_total_o
);
    inc_t             ev_amt [NUM_EV];
    inc_t             inc_q  [NUM_EV];
    logic [TOT_W-1:0] tot_q  [NUM_EV];

    probe_event_decode #(.DATA_W(DATA_W)) u_decode (
        .aw_valid (aw_valid),
        .aw_ready (aw_ready),
        .aw_len   (aw_len),
        .aw_size  (aw_size),
        .w_valid  (w_valid),
        .w_ready  (w_ready),
        .w_strb   (w_strb),
        .b_valid  (b_valid),
        .b_ready  (b_ready),
        .ar_valid (ar_valid),
        .ar_ready (ar_ready),
        .ar_len   (ar_len),
        .ar_size  (ar_size),
        .r_valid  (r_valid),
        .r_ready  (r_ready),
        .busy     (busy),
        .ev_amt   (ev_amt)
    );

    probe_accum #(.TOT_W(TOT_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_amt (ev_amt),
        .inc_q  (inc_q),
        .tot_q  (tot_q)
    );

    for (genvar k = 0; k < NUM_EV; k++) begin : g_flat
        assign evt_inc_o[k*INC_W +: INC_W]   = inc_q[k];
        assign evt_total_o[k*TOT_W +: TOT_W] = tot_q[k];
    end

    // R1: address stall seen one cycle later
    a_r1_aw_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && !aw_ready) |=> (inc_q[EV_AW_STALL] == INC_W'(1)));
    // R2: read-data starve seen one cycle later
    a_r2_r_starve: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ready && !r_valid) |=> (inc_q[EV_R_STARVE] == INC_W'(1)));
    // R3: a write-data slot is either stalled, starved or done, never two at once
    a_r3_w_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({inc_q[EV_W_STALL] != '0, inc_q[EV_W_STARVE] != '0,
                    inc_q[EV_W_DONE] != '0}) <= 1);
    // R4: response done follows its handshake
    a_r4_b_done: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && b_ready) |=> (inc_q[EV_B_DONE] == INC_W'(1)));
    // R5: no burst bytes without an address handshake
    a_r5_aw_bytes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(aw_valid && aw_ready) |=> (inc_q[EV_AW_BYTES] == '0));
    // R6: a write beat never carries more bytes than the strobe width
    a_r6_w_bytes_bound: assert property (@(posedge clk) disable iff (!rst_n)
        inc_q[EV_W_BYTES] <= INC_W'(STRB_W));
    // R7: busy amount follows the busy flag
    a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (inc_q[EV_BUSY] == INC_W'(1)));
endmodule

// File: tb/axi_traffic_probe_test.sv
`timescale 1ns/1ps
module axi_traffic_probe_test;
    localparam int NEV = 16;
    localparam int IW  = 16;
    localparam int TW  = 48;
    localparam int DW  = 64;
    localparam int SW  = DW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic aw_valid = 0, aw_ready = 0, w_valid = 0, w_ready = 0;
    logic b_valid = 0, b_ready = 0, ar_valid = 0, ar_ready = 0;
    logic r_valid = 0, r_ready = 0, busy = 0;
    logic [7:0] aw_len = 0, ar_len = 0;
    logic [2:0] aw_size = 0, ar_size = 0;
    logic [SW-1:0] w_strb = 0;
    logic [NEV*IW-1:0] evt_inc_o;
    logic [NEV*TW-1:0] evt_total_o;

    int tests = 0;
    int fails = 0;
    logic [TW-1:0] tot_exp [NEV];

    always #2 clk = ~clk;

    axi_traffic_probe uut (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_len(aw_len), .aw_size(aw_size),
        .w_valid(w_valid), .w_ready(w_ready), .w_strb(w_strb),
        .b_valid(b_valid), .b_ready(b_ready),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_len(ar_len), .ar_size(ar_size),
        .r_valid(r_valid), .r_ready(r_ready), .busy(busy),
        .evt_inc_o(evt_inc_o), .evt_total_o(evt_total_o)
    );

    function automatic string req_of(int k);
        if (k <= 1) return "R1";
        if (k <= 3) return "R2";
        if (k <= 5) return "R3";
        if (k <= 10) return "R4";
        if (k <= 12) return "R5";
        if (k <= 14) return "R6";
        return "R7";
    endfunction

    function automatic int exp_amt(int k);
        case (k)
            0:  return int'(aw_valid & ~aw_ready);
            1:  return int'(ar_valid & ~ar_ready);
            2:  return int'(w_valid & ~w_ready);
            3:  return int'(r_ready & ~r_valid);
            4:  return int'(w_ready & ~w_valid);
            5:  return int'(r_valid & ~r_ready);
            6:  return int'(aw_valid & aw_ready);
            7:  return int'(ar_valid & ar_ready);
            8:  return int'(w_valid & w_ready);
            9:  return int'(r_valid & r_ready);
            10: return int'(b_valid & b_ready);
            11: return (aw_valid & aw_ready) ? ((int'(aw_len) + 1) << aw_size) : 0;
            12: return (ar_valid & ar_ready) ? ((int'(ar_len) + 1) << ar_size) : 0;
            13: return (w_valid & w_ready) ? $countones(w_strb) : 0;
            14: return (r_valid & r_ready) ? SW : 0;
            default: return int'(busy);
        endcase
    endfunction

    // One bus cycle: expectation from the inputs now held, sampled after the edge (R8, R9)
    task automatic step(string tag);
        int e [NEV];
        for (int k = 0; k < NEV; k++) e[k] = exp_amt(k);
        @(posedge clk);
        #1;
        for (int k = 0; k < NEV; k++) begin
            tot_exp[k] = tot_exp[k] + TW'(e[k]);
            tests++;
            if (evt_inc_o[k*IW +: IW] !== IW'(e[k])) begin
                fails++;
                $display("FAIL %s R8 %s slot %0d amount: got %0d expected %0d",
                         tag, req_of(k), k, evt_inc_o[k*IW +: IW], e[k]);
            end
            tests++;
            if (evt_total_o[k*TW +: TW] !== tot_exp[k]) begin
                fails++;
                $display("FAIL %s R9 slot %0d total: got %0d expected %0d",
                         tag, k, evt_total_o[k*TW +: TW], tot_exp[k]);
            end
        end
    endtask

    task automatic idle_inputs();
        aw_valid = 0; aw_ready = 0; w_valid = 0; w_ready = 0;
        b_valid = 0; b_ready = 0; ar_valid = 0; ar_ready = 0;
        r_valid = 0; r_ready = 0; busy = 0;
        aw_len = 0; ar_len = 0; aw_size = 0; ar_size = 0; w_strb = 0;
    endtask

    task automatic check_all_zero(string tag);
        tests++;
        if (evt_inc_o !== '0 || evt_total_o !== '0) begin
            fails++;
            $display("FAIL %s R10 outputs not cleared: inc=%h total=%h expected 0",
                     tag, evt_inc_o, evt_total_o);
        end
    endtask

    task automatic t_reset();
        #1;
        check_all_zero("power-on reset");
        for (int k = 0; k < NEV; k++) tot_exp[k] = '0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    // R1, R2: valid offered, ready withheld; r_ready without data
    task automatic t_stalls();
        @(negedge clk);
        idle_inputs();
        aw_valid = 1; ar_valid = 1; w_valid = 1; r_ready = 1; w_strb = 8'hFF;
        step("stalls");
        @(negedge clk); step("stalls hold");
        @(negedge clk); idle_inputs(); step("stalls released");
    endtask

    // R3: ready without valid on W, data without ready on R
    task automatic t_starves();
        @(negedge clk);
        idle_inputs();
        w_ready = 1; r_valid = 1; b_valid = 1; aw_ready = 1;
        step("starves");
        @(negedge clk); idle_inputs(); step("starves released");
    endtask

    // R4, R5, R6: every channel completes a handshake
    task automatic t_handshakes();
        @(negedge clk);
        idle_inputs();
        aw_valid = 1; aw_ready = 1; aw_len = 8'd3; aw_size = 3'd2;
        ar_valid = 1; ar_ready = 1; ar_len = 8'd0; ar_size = 3'd3;
        w_valid = 1; w_ready = 1; w_strb = 8'b1011_0001;
        r_valid = 1; r_ready = 1; b_valid = 1; b_ready = 1;
        step("handshake small");
        @(negedge clk);
        aw_len = 8'd255; aw_size = 3'd7;
        ar_len = 8'd15;  ar_size = 3'd0;
        w_strb = 8'hFF;
        step("handshake max burst");
        @(negedge clk);
        aw_len = 8'd0; aw_size = 3'd0; w_strb = 8'h00;
        step("handshake one byte, empty strobe");
        @(negedge clk); idle_inputs(); step("handshake idle");
    endtask

    // R7
    task automatic t_busy();
        @(negedge clk);
        idle_inputs(); busy = 1;
        step("busy 1");
        @(negedge clk); step("busy 2");
        @(negedge clk); busy = 0; step("busy off");
    endtask

    // R10: reset in the middle of traffic
    task automatic t_mid_reset();
        @(negedge clk);
        idle_inputs(); busy = 1; aw_valid = 1;
        step("pre-reset");
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_all_zero("mid-run reset");
        for (int k = 0; k < NEV; k++) tot_exp[k] = '0;
        @(negedge clk); rst_n = 1'b1;
        step("after reset");
        @(negedge clk); idle_inputs(); step("after reset idle");
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: got no finish expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_stalls();
        t_starves();
        t_handshakes();
        t_busy();
        t_mid_reset();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule